// File: doc/BRIEF.md
# Multiplexed-Address Asynchronous DRAM Controller

This block connects a synchronous host port to a 4M x 16 asynchronous DRAM with active-low strobes. The host offers one word access at a time over a valid/ready handshake, with a 22-bit word address, a direction bit, two byte-lane enables and 16 bits of write data. The controller splits the address into a 12-bit row and a 10-bit column and puts them on one shared address bus in turn. It sequences the row strobe, the two byte-lane column strobes, write enable and output enable, and drives the data bus only while writing. A read returns the sampled word together with a single-cycle valid pulse.

A free-running interval counter schedules refresh. When refresh is due, the controller runs a column-before-row refresh at the next idle point between accesses. That refresh takes precedence over any host request that is waiting. All pulse widths, the row-to-column delay, address setup and hold, and the row precharge time are parameters counted in controller clocks.

Top module: `dram_ctl`

## Requirements
- R1: On an access, when the row strobe falls, the address bus carries host address bits 21:10.
- R2: On an access, when the column strobe(s) fall, the address bus carries host address bits 9:0 in its low 10 bits, and its top 2 bits are zero.
- R3: Around every access strobe falling edge, the address bus is unchanged for at least T_ASU clocks before the edge and at least T_AH clocks after it.
- R4: Byte enable bit 1 selects the upper lane (data bits 15:8, upper column strobe) and bit 0 the lower lane (bits 7:0, lower column strobe). During an access, a column strobe is asserted only if its enable bit is set.
- R5: In a write access, write enable is low and the data bus output enable is high when the column strobes fall, and the data bus carries the host write data.
- R6: In a read access, output enable is low when the column strobes fall. Write enable stays high for the whole read and the data bus is not driven. rd_data returns the bus value sampled on the last clock of the column strobe, for the enabled lanes.
- R7: In a refresh, both column strobes fall together while the row strobe is high and write enable is high. They stay low for at least T_CSR clocks before the row strobe falls. When the controller is otherwise idle, refresh cycles begin exactly REF_PERIOD clocks apart.
- R8: The row strobe stays high for at least T_RP clocks between any two cycles.
- R9: A request is taken only while req_ready is high. req_ready goes low on the clock after acceptance and stays low at least until the access and its precharge have finished, which is T_ASU+T_AH+max(T_ASU,T_RCD-T_AH)+max(T_CAS,T_AH)+T_RP clocks.
- R10: Each read produces exactly one single-cycle rd_valid pulse, and each write produces none.
- R11: A refresh never starts inside an access. Under continuous host traffic, refresh still takes place every REF_PERIOD clocks on average.
- R12: While and just after reset, all strobes, write enable and output enable are high, the data bus is not driven, rd_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper 12 bits |
| req_be | input | 2 | Byte-lane enables, bit 1 = upper byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse when rd_data is valid |
| rd_data | output | 16 | Read data |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_in | input | 16 | Data returned by the memory |
| dram_dq_oe | output | 1 | Data bus driver enable |

## Verification
The bench decodes the memory pins with its own small memory model. Partial-lane writes followed by full reads show whether the wrong column strobe fired, because a byte from the other lane would then be corrupted or lost. Addresses with all row bits set and all column bits clear, and the reverse, expose a swapped or misaligned row/column split. The same addresses also show a bus that changes too close to a strobe edge through the setup and hold counts. Long runs of back-to-back requests across several refresh intervals catch two faults: a refresh that cuts into an access, and a refresh that is starved by the host. An idle stretch measures the exact spacing between refreshes.

// File: rtl/dram_ctl.sv
module dram_ctl #(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 10,
  parameter int DW         = 16,
  parameter int T_ASU      = 2,
  parameter int T_AH       = 2,
  parameter int T_RCD      = 4,
  parameter int T_CAS      = 3,
  parameter int T_RP       = 3,
  parameter int T_CSR      = 2,
  parameter int T_RASR     = 4,
  parameter int REF_PERIOD = 780
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [1:0]             req_be,
  input  logic [DW-1:0]          req_wdata,
  output logic                   rd_valid,
  output logic [DW-1:0]          rd_data,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_ucas_n,
  output logic                   dram_lcas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DW-1:0]          dram_dq_out,
  input  logic [DW-1:0]          dram_dq_in,
  output logic                   dram_dq_oe
);
  localparam int AW    = ROW_W + COL_W;
  localparam int L_COL = (T_RCD - T_AH > T_ASU) ? T_RCD - T_AH : T_ASU;
  localparam int L_CAS = (T_CAS > T_AH) ? T_CAS : T_AH;
  localparam int CW    = 8;
  localparam int RW    = $clog2(REF_PERIOD);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_RAS, S_COL, S_CAS, S_PRE, S_RCAS, S_RRAS
  } st_t;

  st_t            state;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  ref_cnt;
  logic           ref_pend;
  logic [AW-1:0]  addr_q;
  logic [1:0]     be_q;
  logic           wr_q;
  logic [DW-1:0]  wdata_q;
  logic           last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
      addr_q   <= '0;
      be_q     <= '0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (!last) cnt <= cnt - 1'b1;
      case (state)
        S_IDLE:
          if (ref_pend) begin
            ref_pend <= 1'b0;
            state    <= S_RCAS;
            cnt      <= CW'(T_CSR - 1);
          end else if (req_valid) begin
            addr_q  <= req_addr;
            be_q    <= req_be;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            state   <= S_ROW;
            cnt     <= CW'(T_ASU - 1);
          end
        S_ROW:  if (last) begin state <= S_RAS; cnt <= CW'(T_AH - 1);  end
        S_RAS:  if (last) begin state <= S_COL; cnt <= CW'(L_COL - 1); end
        S_COL:  if (last) begin state <= S_CAS; cnt <= CW'(L_CAS - 1); end
        S_CAS:
          if (last) begin
            if (!wr_q) begin
              rd_data  <= dram_dq_in;
              rd_valid <= 1'b1;
            end
            state <= S_PRE;
            cnt   <= CW'(T_RP - 1);
          end
        S_PRE:  if (last) state <= S_IDLE;
        S_RCAS: if (last) begin state <= S_RRAS; cnt <= CW'(T_RASR - 1); end
        S_RRAS: if (last) begin state <= S_PRE;  cnt <= CW'(T_RP - 1);   end
        default: state <= S_IDLE;
      endcase
      if (ref_cnt == RW'(REF_PERIOD - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  logic col_ph, refr;
  assign col_ph = (state == S_COL) || (state == S_CAS);
  assign refr   = (state == S_RCAS) || (state == S_RRAS);

  assign req_ready   = (state == S_IDLE) && !ref_pend;
  assign dram_addr   = col_ph ? {{(ROW_W-COL_W){1'b0}}, addr_q[COL_W-1:0]}
                              : addr_q[AW-1:COL_W];
  assign dram_ras_n  = !((state == S_RAS) || col_ph || (state == S_RRAS));
  assign dram_ucas_n = !(((state == S_CAS) && be_q[1]) || refr);
  assign dram_lcas_n = !(((state == S_CAS) && be_q[0]) || refr);
  assign dram_we_n   = !(col_ph && wr_q);
  assign dram_oe_n   = !((state == S_CAS) && !wr_q);
  assign dram_dq_oe  = col_ph && wr_q;
  assign dram_dq_out = wdata_q;

  logic [CW-1:0] ras_hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) ras_hi_cnt <= CW'(T_RP);
    else if (!dram_ras_n) ras_hi_cnt <= '0;
    else if (ras_hi_cnt != '1) ras_hi_cnt <= ras_hi_cnt + 1'b1;
  end

  // R6
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> dram_we_n);
  // R5
  drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_we_n && dram_oe_n));
  // R7
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n && (!dram_ucas_n || !dram_lcas_n)) |->
      (!dram_ucas_n && !dram_lcas_n && dram_we_n));
  // R8
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi_cnt >= CW'(T_RP)));
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/tb_dram_ctl.sv
module tb_dram_ctl;
  localparam int T_ASU = 2, T_AH = 2, T_RCD = 4, T_CAS = 3, T_RP = 3;
  localparam int T_CSR = 2, T_RASR = 4, REF_P = 300;
  localparam int L_COL = (T_RCD - T_AH > T_ASU) ? T_RCD - T_AH : T_ASU;
  localparam int L_CAS = (T_CAS > T_AH) ? T_CAS : T_AH;
  localparam int CYC = T_ASU + T_AH + L_COL + L_CAS + T_RP;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ready, rd_valid;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, rd_data, dram_dq_out, dram_dq_in;
  logic [11:0] dram_addr;
  logic dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  always #10 clk = ~clk;

  dram_ctl #(.T_ASU(T_ASU), .T_AH(T_AH), .T_RCD(T_RCD), .T_CAS(T_CAS),
             .T_RP(T_RP), .T_CSR(T_CSR), .T_RASR(T_RASR), .REF_PERIOD(REF_P)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
    .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in), .dram_dq_oe(dram_dq_oe));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [15:0] mdl [int];
  logic [15:0] shadow [int];
  logic [15:0] dq_drive = 16'h0;
  assign dram_dq_in = (!dram_oe_n && !(dram_ucas_n && dram_lcas_n)) ? dq_drive : 16'h5A5A;

  logic [11:0] exp_row, exp_col;
  logic [1:0]  exp_be;
  logic        exp_wr;
  logic [15:0] exp_data;

  int cyc = 0, ref_n = 0, last_ref = 0, prev_ref = 0;
  int stab = 0, ras_hi = 1000, cas_lo = 0, since_r = 0, since_c = 0;
  bit hold_r = 0, hold_c = 0;
  logic p_ras = 1, p_uc = 1, p_lc = 1;
  logic [11:0] p_addr = '0, row_seen = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit cfall;
      int key;
      cyc++; since_r++; since_c++;
      if (dram_addr != p_addr) begin
        if (hold_r) chk(since_r >= T_AH, "R3 row hold", since_r, T_AH);
        if (hold_c) chk(since_c >= T_AH, "R3 col hold", since_c, T_AH);
        hold_r = 0; hold_c = 0; stab = 1;
      end else stab++;
      cfall = (p_uc && !dram_ucas_n) || (p_lc && !dram_lcas_n);
      if (cfall && dram_ras_n) begin
        chk(!dram_ucas_n && !dram_lcas_n && dram_we_n, "R7 refresh strobes",
            {dram_ucas_n, dram_lcas_n, dram_we_n}, 3'b001);
        chk(ras_hi >= T_RP, "R11 refresh after full precharge", ras_hi, T_RP);
        ref_n++; prev_ref = last_ref; last_ref = cyc;
      end
      if (p_ras && !dram_ras_n) begin
        if (!dram_ucas_n && !dram_lcas_n)
          chk(cas_lo >= T_CSR, "R7 cas lead", cas_lo, T_CSR);
        else begin
          chk(dram_addr == exp_row, "R1 row addr", dram_addr, exp_row);
          chk(stab >= T_ASU + 1, "R3 row setup", stab - 1, T_ASU);
          chk(ras_hi >= T_RP, "R8 precharge", ras_hi, T_RP);
          hold_r = 1; since_r = 0; row_seen = dram_addr;
        end
      end
      if (cfall && !dram_ras_n) begin
        chk(dram_addr == exp_col, "R2 col addr", dram_addr, exp_col);
        chk(stab >= T_ASU + 1, "R3 col setup", stab - 1, T_ASU);
        chk({!dram_ucas_n, !dram_lcas_n} == exp_be, "R4 lanes",
            {!dram_ucas_n, !dram_lcas_n}, exp_be);
        key = int'({row_seen, dram_addr[9:0]});
        if (exp_wr) begin
          chk(!dram_we_n && dram_dq_oe && dram_dq_out == exp_data, "R5 write pins",
              {dram_we_n, dram_dq_oe, dram_dq_out}, {2'b01, exp_data});
          if (!mdl.exists(key)) mdl[key] = 16'h0;
          if (!dram_ucas_n) mdl[key][15:8] = dram_dq_out[15:8];
          if (!dram_lcas_n) mdl[key][7:0]  = dram_dq_out[7:0];
        end else begin
          chk(!dram_oe_n && dram_we_n && !dram_dq_oe, "R6 read pins",
              {dram_oe_n, dram_we_n, dram_dq_oe}, 3'b010);
          dq_drive = mdl.exists(key) ? mdl[key] : 16'h0;
        end
        hold_c = 1; since_c = 0;
      end
      if (!dram_ras_n && !exp_wr && !dram_we_n)
        chk(0, "R6 we during read", 0, 1);
      ras_hi = dram_ras_n ? ras_hi + 1 : 0;
      cas_lo = (!dram_ucas_n && !dram_lcas_n) ? cas_lo + 1 : 0;
      p_ras = dram_ras_n; p_uc = dram_ucas_n; p_lc = dram_lcas_n; p_addr = dram_addr;
    end
  end

  task automatic access(input bit wr, input logic [21:0] a, input logic [1:0] be,
                        input logic [15:0] d);
    int busy = 0, pulses = 0, t = 0;
    int k = int'(a);
    logic [15:0] got = '0, m;
    @(negedge clk);
    while (!req_ready && t < 2000) begin @(negedge clk); t++; end
    exp_row = a[21:10]; exp_col = {2'b00, a[9:0]}; exp_be = be; exp_wr = wr; exp_data = d;
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R9 ready drops", req_ready, 0);
    while (!req_ready && busy < 2000) begin
      if (rd_valid) begin pulses++; got = rd_data; end
      busy++;
      @(negedge clk);
    end
    if (rd_valid) begin pulses++; got = rd_data; end
    chk(busy >= CYC, "R9 busy span", busy, CYC);
    if (!shadow.exists(k)) shadow[k] = 16'h0;
    if (wr) begin
      if (be[1]) shadow[k][15:8] = d[15:8];
      if (be[0]) shadow[k][7:0]  = d[7:0];
      chk(pulses == 0, "R10 no pulse on write", pulses, 0);
    end else begin
      m = {{8{be[1]}}, {8{be[0]}}};
      chk(pulses == 1, "R10 one pulse", pulses, 1);
      chk((got & m) == (shadow[k] & m), "R6 read data", got & m, shadow[k] & m);
    end
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n,
        "R12 strobes idle in reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'h1f);
    rst_n = 1;
    @(negedge clk);
    chk(!dram_dq_oe && !rd_valid && req_ready, "R12 after reset",
        {dram_dq_oe, rd_valid, req_ready}, 3'b001);
  endtask

  task automatic t_basic;
    access(1, 22'h12345, 2'b11, 16'hBEEF);
    access(0, 22'h12345, 2'b11, 16'h0);
    access(1, 22'h00400, 2'b11, 16'h1234);
    access(0, 22'h00400, 2'b11, 16'h0);
  endtask

  task automatic t_lanes;
    access(1, 22'h2A0F0, 2'b11, 16'h0000);
    access(1, 22'h2A0F0, 2'b01, 16'hAA55);
    access(0, 22'h2A0F0, 2'b11, 16'h0);
    access(1, 22'h2A0F0, 2'b10, 16'hC3FF);
    access(0, 22'h2A0F0, 2'b11, 16'h0);
    access(0, 22'h2A0F0, 2'b10, 16'h0);
    access(0, 22'h2A0F0, 2'b01, 16'h0);
  endtask

  task automatic t_edges;
    access(1, 22'h3FFFFF, 2'b11, 16'hF00D);
    access(1, 22'h000000, 2'b11, 16'h0F0F);
    access(1, 22'h3FFC00, 2'b11, 16'h8001);
    access(1, 22'h0003FF, 2'b11, 16'h7FFE);
    access(0, 22'h3FFFFF, 2'b11, 16'h0);
    access(0, 22'h000000, 2'b11, 16'h0);
    access(0, 22'h3FFC00, 2'b11, 16'h0);
    access(0, 22'h0003FF, 2'b11, 16'h0);
  endtask

  task automatic t_traffic;
    int r0 = ref_n, c0 = cyc, exp_min;
    for (int i = 0; i < 120; i++)
      access(i[0], 22'(i * 4099), 2'b11, 16'(i * 313));
    exp_min = (cyc - c0) / REF_P - 1;
    chk(ref_n - r0 >= exp_min, "R11 refresh not starved", ref_n - r0, exp_min);
  endtask

  task automatic t_idle_refresh;
    int r0 = ref_n, t = 0;
    while (ref_n < r0 + 3 && t < 5 * REF_P) begin @(negedge clk); t++; end
    chk(last_ref - prev_ref == REF_P, "R7 refresh interval", last_ref - prev_ref, REF_P);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_basic;
    t_lanes;
    t_edges;
    t_idle_refresh;
    t_traffic;
    t_idle_refresh;
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule